// File: doc/BRIEF.md
# Accurate 8x8 Integer Forward DCT

This block turns an 8x8 tile of signed 16-bit samples into 64 forward-DCT coefficients, using fixed-point multipliers scaled by 2^13. Samples arrive one tile row per beat on a valid/ready handshake. Coefficients leave one coefficient row per beat, with a valid strobe, in the same row-major order.

Internally one combinational 1-D transform engine serves both passes. In the row pass, each incoming row is transformed and written into an 8x8 tile buffer. The column pass then reads each buffer column, transforms it with column scaling, and writes the result back in place. The final rows are then streamed out. A new tile is accepted only once the previous one has fully left the buffer.

Top module: `fdct8x8`

## Requirements
- R1: After reset, inReady is 1 and outValid is 0.
- R2: While inReady is 1, a beat is taken on every clock edge where inValid is 1. Eight taken beats form one tile. Outputs appear only after a whole tile has been taken.
- R3: In the row pass, terms 0 and 4 are the even sum and even difference shifted left by 2. Every row-pass result is cut to its low 16 bits (two's-complement wrap) before the column pass.
- R4: In the column pass, terms 0 and 4 have 2 added and are then shifted right arithmetically by 2.
- R5: Every multiplied term is a wide signed sum of products of the 2^13-scaled constants. Half an LSB is added, and the sum is then shifted right arithmetically by 11 in the row pass or by 15 in the column pass. The result is cut to 16 bits.
- R6: Let d7=x0-x7, d6=x1-x6, d5=x2-x5, d4=x3-x4. Then z3=d4+d6 and z4=d5+d7. The two shared terms are P=z3*(9633-16069)+z4*9633 and Q=z3*9633+z4*(9633-3196). The odd terms are: term 7 = d4*(2446-7373) - d7*7373 + P; term 1 = -d4*7373 + d7*(12299-7373) + Q; term 5 = d5*(16819-20995) - d6*20995 + Q; term 3 = -d5*20995 + d6*(25172-20995) + P. Terms 2 and 6 use t13=s0-s3 and t12=s1-s2, where si=xi+x(7-i). Term 2 = t13*10703 + t12*4433. Term 6 = t13*4433 + t12*(4433-15137).
- R7: After the eighth beat of a tile is taken, inReady stays 0 for eight column cycles. outValid is then 1 for exactly eight consecutive cycles, with inReady still 0. So the first output row is seen 9 cycles after the last input edge. inReady returns to 1 in the cycle after the last output row.
- R8: Output beat k carries the coefficients of vertical frequency k. Element j sits at bits [16j+15:16j] and is horizontal frequency j. Input element j of row r sits at the same bit position.
- R9: inValid and inRow have no effect while inReady is 0.
- R10: A tile whose samples all equal v gives 64*v at coefficient (0,0) and 0 everywhere else.
- R11: Idle cycles with inValid at 0 between input beats do not change the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Input row is presented |
| inReady | output | 1 | Block will take an input row this cycle |
| inRow | input | 128 | Eight signed 16-bit samples, element j at bits [16j+15:16j] |
| outValid | output | 1 | Output row is presented |
| outRow | output | 128 | Eight signed 16-bit coefficients, element j at bits [16j+15:16j] |

## Verification
The assertions assume that the source holds inValid low, or keeps offering data harmlessly, while inReady is 0. They also assume that the sink takes each output row the cycle it appears, since the output has no back-pressure. The stimulus follows this: it offers a row only after it has seen inReady high at the falling edge, and it reads every outValid cycle. During busy cycles it sometimes drives inValid high with random rows, to show those rows are dropped. Sample values range from level-shifted 8-bit data up to full-scale and alternating extremes. At full scale the row-pass results wrap, and the reference model wraps them in the same way.

// File: rtl/fdct_pkg.sv
package fdct_pkg;
  localparam int DCT_N      = 8;
  localparam int HALF_N     = DCT_N / 2;
  localparam int IDX_W      = $clog2(DCT_N);
  localparam int CONST_BITS = 13;
  localparam int PASS_BITS  = 2;
  localparam int ROW_SH     = CONST_BITS - PASS_BITS;
  localparam int COL_SH     = CONST_BITS + PASS_BITS;

  // cosine-derived multipliers scaled by 2^13
  localparam int K_0298 = 2446;
  localparam int K_0390 = 3196;
  localparam int K_0541 = 4433;
  localparam int K_0765 = 6270;
  localparam int K_0899 = 7373;
  localparam int K_1175 = 9633;
  localparam int K_1501 = 12299;
  localparam int K_1847 = 15137;
  localparam int K_1961 = 16069;
  localparam int K_2053 = 16819;
  localparam int K_2562 = 20995;
  localparam int K_3072 = 25172;

  typedef enum logic [1:0] {ST_LOAD, ST_COLS, ST_EMIT} fdct_state_t;

  typedef struct packed {
    logic             wrRow;
    logic             wrCol;
    logic             colMode;
    logic [IDX_W-1:0] idx;
  } fdct_strobe_t;
endpackage

// File: rtl/fdct_engine.sv
module fdct_engine
  import fdct_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ACC_W  = 40
) (
  input  logic [DCT_N*DATA_W-1:0] vecIn,
  input  logic                    colMode,
  output logic [DCT_N*DATA_W-1:0] vecOut
);
  typedef logic signed [ACC_W-1:0] acc_t;

  localparam acc_t C2A = acc_t'(K_0541 + K_0765);
  localparam acc_t C2B = acc_t'(K_0541);
  localparam acc_t C6B = acc_t'(K_0541 - K_1847);
  localparam acc_t CZA = acc_t'(K_1175 - K_1961);
  localparam acc_t CZB = acc_t'(K_1175);
  localparam acc_t CZC = acc_t'(K_1175 - K_0390);
  localparam acc_t C7A = acc_t'(K_0298 - K_0899);
  localparam acc_t CN9 = acc_t'(-K_0899);
  localparam acc_t C1B = acc_t'(K_1501 - K_0899);
  localparam acc_t C5A = acc_t'(K_2053 - K_2562);
  localparam acc_t CN5 = acc_t'(-K_2562);
  localparam acc_t C3B = acc_t'(K_3072 - K_2562);
  localparam acc_t ROW_RND = acc_t'(1) <<< (ROW_SH - 1);
  localparam acc_t COL_RND = acc_t'(1) <<< (COL_SH - 1);
  localparam acc_t EVEN_RND = acc_t'(1) <<< (PASS_BITS - 1);

  acc_t x [DCT_N];
  acc_t s [HALF_N];
  acc_t d [HALF_N];
  acc_t res [DCT_N];

  for (genvar i = 0; i < DCT_N; i++) begin : g_unpack
    assign x[i] = acc_t'($signed(vecIn[i*DATA_W +: DATA_W]));
    assign vecOut[i*DATA_W +: DATA_W] = res[i][DATA_W-1:0];
  end

  for (genvar i = 0; i < HALF_N; i++) begin : g_fly
    assign s[i] = x[i] + x[DCT_N-1-i];
    assign d[i] = x[i] - x[DCT_N-1-i];
  end

  function automatic acc_t descale(input acc_t v, input logic col);
    if (col) return (v + COL_RND) >>> COL_SH;
    return (v + ROW_RND) >>> ROW_SH;
  endfunction

  acc_t e10, e11, e12, e13, z3, z4, zP, zQ;

  always_comb begin
    e10 = s[0] + s[3];
    e13 = s[0] - s[3];
    e11 = s[1] + s[2];
    e12 = s[1] - s[2];
    if (colMode) begin
      res[0] = (e10 + e11 + EVEN_RND) >>> PASS_BITS;
      res[4] = (e10 - e11 + EVEN_RND) >>> PASS_BITS;
    end else begin
      res[0] = (e10 + e11) <<< PASS_BITS;
      res[4] = (e10 - e11) <<< PASS_BITS;
    end
    res[2] = descale(e13 * C2A + e12 * C2B, colMode);
    res[6] = descale(e13 * C2B + e12 * C6B, colMode);
    // d[0]=x0-x7, d[1]=x1-x6, d[2]=x2-x5, d[3]=x3-x4
    z3 = d[3] + d[1];
    z4 = d[2] + d[0];
    zP = z3 * CZA + z4 * CZB;
    zQ = z3 * CZB + z4 * CZC;
    res[7] = descale(d[3] * C7A + d[0] * CN9 + zP, colMode);
    res[1] = descale(d[3] * CN9 + d[0] * C1B + zQ, colMode);
    res[5] = descale(d[2] * C5A + d[1] * CN5 + zQ, colMode);
    res[3] = descale(d[2] * CN5 + d[1] * C3B + zP, colMode);
  end
endmodule

// File: rtl/fdct_datapath.sv
module fdct_datapath
  import fdct_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ACC_W  = 40
) (
  input  logic                    clk,
  input  fdct_strobe_t            strobe,
  input  logic [DCT_N*DATA_W-1:0] inRow,
  output logic [DCT_N*DATA_W-1:0] outRow
);
  localparam int VEC_W = DCT_N * DATA_W;

  logic [DATA_W-1:0] tile [DCT_N][DCT_N];
  logic [VEC_W-1:0]  colVec, engIn, engOut;

  for (genvar r = 0; r < DCT_N; r++) begin : g_tap
    assign colVec[r*DATA_W +: DATA_W] = tile[r][strobe.idx];
    assign outRow[r*DATA_W +: DATA_W] = tile[strobe.idx][r];
  end

  assign engIn = strobe.colMode ? colVec : inRow;

  fdct_engine #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_engine (
    .vecIn  (engIn),
    .colMode(strobe.colMode),
    .vecOut (engOut)
  );

  always_ff @(posedge clk) begin
    for (int k = 0; k < DCT_N; k++) begin
      if (strobe.wrRow)      tile[strobe.idx][k] <= engOut[k*DATA_W +: DATA_W];
      else if (strobe.wrCol) tile[k][strobe.idx] <= engOut[k*DATA_W +: DATA_W];
    end
  end
endmodule

// File: rtl/fdct_ctrl.sv
module fdct_ctrl
  import fdct_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  output logic         inReady,
  output logic         outValid,
  output fdct_strobe_t strobe
);
  fdct_state_t      state;
  logic [IDX_W-1:0] cnt;
  logic             step;
  logic             lastIdx;

  assign step    = (state != ST_LOAD) || inValid;
  assign lastIdx = (cnt == IDX_W'(DCT_N - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_LOAD;
      cnt   <= '0;
    end else if (step) begin
      cnt <= lastIdx ? '0 : cnt + 1'b1;
      if (lastIdx) begin
        case (state)
          ST_LOAD: state <= ST_COLS;
          ST_COLS: state <= ST_EMIT;
          default: state <= ST_LOAD;
        endcase
      end
    end
  end

  always_comb begin
    inReady        = (state == ST_LOAD);
    outValid       = (state == ST_EMIT);
    strobe.wrRow   = (state == ST_LOAD) && inValid;
    strobe.wrCol   = (state == ST_COLS);
    strobe.colMode = (state == ST_COLS);
    strobe.idx     = cnt;
  end
endmodule

// File: rtl/fdct8x8.sv
module fdct8x8
  import fdct_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ACC_W  = 40
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    inValid,
  output logic                    inReady,
  input  logic [DCT_N*DATA_W-1:0] inRow,
  output logic                    outValid,
  output logic [DCT_N*DATA_W-1:0] outRow
);
  fdct_strobe_t strobe;

  fdct_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .inReady (inReady),
    .outValid(outValid),
    .strobe  (strobe)
  );

  fdct_datapath #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_dp (
    .clk   (clk),
    .strobe(strobe),
    .inRow (inRow),
    .outRow(outRow)
  );
endmodule

// File: rtl/fdct8x8_chk.sv
module fdct8x8_chk
  import fdct_pkg::*;
(
  input logic clk,
  input logic rstN,
  input logic inValid,
  input logic inReady,
  input logic outValid
);
  logic [IDX_W-1:0] fillCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) fillCnt <= '0;
    else if (inValid && inReady) fillCnt <= fillCnt + 1'b1;
  end

  p_idle_after_reset_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (inReady && !outValid));

  p_emit_whole_block_r2: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (fillCnt == '0));

  p_busy_blocks_input_r7: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> !inReady);

  p_cols_after_fill_r7: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady && fillCnt == IDX_W'(DCT_N - 1)) |=> (!inReady && !outValid));

  p_ready_after_emit_r7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(outValid) |-> inReady);

  p_column_gap_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(outValid) |-> !$past(inReady, 8));
endmodule

bind fdct8x8 fdct8x8_chk u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .inValid (inValid),
  .inReady (inReady),
  .outValid(outValid)
);

// File: tb/tb_fdct8x8.sv
`timescale 1ns/1ps
module tb_fdct8x8;
  logic         clk = 1'b0;
  logic         rstN;
  logic         inValid;
  logic         inReady;
  logic [127:0] inRow;
  logic         outValid;
  logic [127:0] outRow;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 0;

  int           blk   [8][8];
  longint       vin   [8];
  longint       vout  [8];
  longint       mid   [8][8];
  longint       coefM [8][8];
  logic [127:0] expQ  [$];
  string        tagQ  [$];

  always #4 clk = ~clk;

  fdct8x8 dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inRow(inRow), .outValid(outValid), .outRow(outRow)
  );

  task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic longint t16(input longint v);
    return longint'(shortint'(v));
  endfunction

  // behavioural 1-D model on vin -> vout
  task automatic ref1d(input bit col);
    longint d7, d6, d5, d4, t10, t11, t12, t13, z3, z4, zp, zq, rnd;
    int sh;
    t10 = (vin[0] + vin[7]) + (vin[3] + vin[4]);
    t13 = (vin[0] + vin[7]) - (vin[3] + vin[4]);
    t11 = (vin[1] + vin[6]) + (vin[2] + vin[5]);
    t12 = (vin[1] + vin[6]) - (vin[2] + vin[5]);
    d7 = vin[0] - vin[7]; d6 = vin[1] - vin[6];
    d5 = vin[2] - vin[5]; d4 = vin[3] - vin[4];
    sh  = col ? 15 : 11;
    rnd = col ? 64'sd16384 : 64'sd1024;
    if (col) begin
      vout[0] = (t10 + t11 + 2) >>> 2;
      vout[4] = (t10 - t11 + 2) >>> 2;
    end else begin
      vout[0] = (t10 + t11) * 4;
      vout[4] = (t10 - t11) * 4;
    end
    vout[2] = (t13 * 10703 + t12 * 4433 + rnd) >>> sh;
    vout[6] = (t13 * 4433 + t12 * (4433 - 15137) + rnd) >>> sh;
    z3 = d4 + d6;
    z4 = d5 + d7;
    zp = z3 * (9633 - 16069) + z4 * 9633;
    zq = z3 * 9633 + z4 * (9633 - 3196);
    vout[7] = (d4 * (2446 - 7373) - d7 * 7373 + zp + rnd) >>> sh;
    vout[1] = (-d4 * 7373 + d7 * (12299 - 7373) + zq + rnd) >>> sh;
    vout[5] = (d5 * (16819 - 20995) - d6 * 20995 + zq + rnd) >>> sh;
    vout[3] = (-d5 * 20995 + d6 * (25172 - 20995) + zp + rnd) >>> sh;
  endtask

  task automatic pushRef(input string tag);
    logic [127:0] row;
    for (int r = 0; r < 8; r++) begin
      for (int c = 0; c < 8; c++) vin[c] = blk[r][c];
      ref1d(1'b0);
      for (int c = 0; c < 8; c++) mid[r][c] = t16(vout[c]);
    end
    for (int c = 0; c < 8; c++) begin
      for (int r = 0; r < 8; r++) vin[r] = mid[r][c];
      ref1d(1'b1);
      for (int k = 0; k < 8; k++) coefM[k][c] = t16(vout[k]);
    end
    for (int k = 0; k < 8; k++) begin
      row = '0;
      for (int j = 0; j < 8; j++) row[j*16 +: 16] = coefM[k][j][15:0];
      expQ.push_back(row);
      tagQ.push_back(tag);
    end
  endtask

  task automatic fillConst(input int v);
    for (int r = 0; r < 8; r++) for (int c = 0; c < 8; c++) blk[r][c] = v;
  endtask

  task automatic pushDc(input int v);
    logic [127:0] row;
    fillConst(v);
    for (int k = 0; k < 8; k++) begin
      row = '0;
      if (k == 0) row[15:0] = 16'(64 * v);
      expQ.push_back(row);
      tagQ.push_back("R10");
    end
  endtask

  task automatic fillRand(input bit wide);
    for (int r = 0; r < 8; r++) for (int c = 0; c < 8; c++)
      blk[r][c] = wide ? int'(shortint'($urandom)) : int'($urandom_range(255)) - 128;
  endtask

  task automatic sendBlock(input int gap, input bit junk);
    for (int r = 0; r < 8; r++) begin
      logic [127:0] row;
      for (int c = 0; c < 8; c++) row[c*16 +: 16] = 16'(blk[r][c]);
      @(negedge clk);
      while (!inReady) begin
        inValid = junk;
        inRow   = {$urandom, $urandom, $urandom, $urandom};
        @(negedge clk);
      end
      inValid = 1'b1;
      inRow   = row;
      @(posedge clk);
      if (gap > 0) begin
        @(negedge clk);
        inValid = 1'b0;
        inRow   = {$urandom, $urandom, $urandom, $urandom};
        repeat (gap - 1) @(negedge clk);
      end
    end
  endtask

  task automatic drainTimed();
    int n = 0;
    int run = 0;
    @(negedge clk);
    inValid = 1'b0;
    n = 1;
    while (!outValid && n < 40) begin @(negedge clk); n++; end
    check(n == 9, "R7 first-output latency", 128'(n), 128'd9);
    while (outValid && run < 40) begin run++; @(negedge clk); end
    check(run == 8, "R7 output run length", 128'(run), 128'd8);
    check(inReady == 1'b1, "R7 ready after emit", 128'(inReady), 128'd1);
  endtask

  // output monitor
  always @(negedge clk) begin
    if (rstN && outValid && !done) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R2 unexpected output", outRow, '0);
      end else begin
        logic [127:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check(outRow === e, {t, " R8 coefficient row"}, outRow, e);
      end
      check(!inReady, "R7 ready low while emitting", 128'(inReady), 128'd0);
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL R2 watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; inValid = 1'b0; inRow = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(inReady == 1'b0 || inReady == 1'b1, "R1 ready known in reset", 128'(inReady), 128'd1);
    rstN = 1'b1;
    @(negedge clk);
    check(inReady == 1'b1, "R1 ready after reset", 128'(inReady), 128'd1);
    check(outValid == 1'b0, "R1 no output after reset", 128'(outValid), 128'd0);

    // DC tiles, hand-computed expectation, with timing
    pushDc(1);  sendBlock(0, 1'b0); drainTimed();
    pushDc(-3); sendBlock(0, 1'b0); drainTimed();

    // ramp: row pass shift, column rounding, odd terms
    for (int r = 0; r < 8; r++) for (int c = 0; c < 8; c++) blk[r][c] = r * 8 + c - 32;
    pushRef("R3 R4 R5 R6"); sendBlock(0, 1'b0); drainTimed();

    // back-to-back random 8-bit tiles with junk during busy
    for (int b = 0; b < 6; b++) begin
      fillRand(1'b0); pushRef("R9 R5 R6"); sendBlock(0, 1'b1);
    end

    // gaps between beats
    for (int b = 0; b < 3; b++) begin
      fillRand(1'b0); pushRef("R11 R4"); sendBlock(2, 1'b0);
    end

    // extreme values, row results wrap
    fillConst(32767);  pushRef("R3 extreme"); sendBlock(0, 1'b1);
    fillConst(-32768); pushRef("R3 extreme"); sendBlock(0, 1'b1);
    for (int r = 0; r < 8; r++) for (int c = 0; c < 8; c++)
      blk[r][c] = ((r + c) % 2 == 0) ? 32767 : -32768;
    pushRef("R3 R5 checker"); sendBlock(1, 1'b1);
    for (int b = 0; b < 4; b++) begin
      fillRand(1'b1); pushRef("R3 R4 R5 R6 wide"); sendBlock(0, 1'b1);
    end

    @(negedge clk);
    inValid = 1'b0;
    for (int w = 0; w < 200 && expQ.size() != 0; w++) @(negedge clk);
    check(expQ.size() == 0, "R2 all rows delivered", 128'(expQ.size()), 128'd0);
    repeat (4) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule